// File: doc/BRIEF.md
# Packed SIMD Integer Lane ALU

This block is the execution stage for a family of packed integer vector operations. Each operation works on one 32-bit slice of a vector register. A 2-bit size code splits the slice into four 8-bit lanes (code 0), two 16-bit lanes (code 1) or one 32-bit lane (code 2). Lane `i` of width `W` sits at bits `[i*W +: W]` of every operand and of the result. Code 3 would mean 64-bit lanes, and no operation of this unit accepts it.

A 5-bit operation code and a variant bit `op_u` together choose the operation. The operations are:
- halving add, rounding halving add and halving subtract
- maximum and minimum
- absolute difference, with or without accumulation
- multiply keeping the low half
- multiply-add and multiply-subtract into the old destination
- carry-less polynomial multiply
- saturating doubling multiply returning the high half, with or without rounding

The caller supplies the old destination slice on `acc_in` for the accumulating operations. The result, a saturation flag and an illegal-encoding flag are registered one clock after `in_valid`. The caller repeats the operation once per slice to cover a whole vector.

Top module: `simd_lane_alu`

## Requirements
- R1: A size code of 3 marks the operation as illegal. The registered result is then zero, `out_illegal` is 1 and `out_sat` is 0. Any operation code other than 0x00, 0x02, 0x04, 0x0C, 0x0D, 0x0E, 0x0F, 0x12, 0x13 and 0x16 is also illegal.
- R2: An accepted operation (`in_valid`=1 at a rising edge) updates `out_data`, `out_sat` and `out_illegal` at that edge and raises `out_valid` for that cycle. When `in_valid` is 0, `out_valid` drops to 0 and the other outputs keep their values. After reset all outputs are 0.
- R3: Op 0x00 gives (a+b)>>1, op 0x02 gives (a+b+1)>>1 and op 0x04 gives (a-b)>>1. Each is computed per lane on a width one bit wider than the lane, so nothing overflows. `op_u`=0 treats lanes as signed and `op_u`=1 treats them as unsigned.
- R4: Op 0x0C returns the larger of the two lanes and op 0x0D the smaller. The comparison is signed when `op_u`=0 and unsigned when `op_u`=1.
- R5: Op 0x0E returns |a-b| per lane, with the same signedness rule as R3. Op 0x0F adds |a-b| to the matching lane of `acc_in`. That add wraps within the lane and carries nothing into the next lane.
- R6: Op 0x13 with `op_u`=0 returns the low lane-width bits of a*b. With `op_u`=1 it returns the low 8 bits of the carry-less (GF(2)) product. The carry-less form is legal only with size code 0; any other size makes it illegal.
- R7: Op 0x12 returns acc+a*b when `op_u`=0 and acc-a*b when `op_u`=1, on the low lane-width bits.
- R8: Op 0x16 treats lanes as signed and returns the high half of 2*a*b. With `op_u`=1 it first adds 1<<(W-1), which rounds the result. It is illegal with size code 0.
- R9: For op 0x16, a lane whose two inputs are both the most negative value returns the largest positive value, and `out_sat` is set. `out_sat` stays 0 for every other operation and for every other input pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| op_u | input | 1 | Variant bit: signedness or the alternate form |
| elem_size | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=reserved |
| src_a | input | 32 | First source slice |
| src_b | input | 32 | Second source slice |
| acc_in | input | 32 | Old destination slice for accumulating operations |
| out_valid | output | 1 | Result registered from an accepted operation |
| out_data | output | 32 | Result slice |
| out_sat | output | 1 | A lane saturated |
| out_illegal | output | 1 | Encoding was reserved or illegal |

## Verification
Every result and flag appears at the first rising edge after its operation is presented, one register deep. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. This places each sample half a period after the edge that loaded the result, and before the next operation can change it. Idle cycles are checked the same way: after a cycle with `in_valid` low, the previous result must still be on the outputs even though the inputs have changed.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    // Operation classes decoded from the opcode and variant bit
    typedef enum logic [3:0] {
        K_HADD,
        K_RHADD,
        K_HSUB,
        K_MAX,
        K_MIN,
        K_ABD,
        K_ABA,
        K_MUL,
        K_MLA,
        K_MLS,
        K_PMUL,
        K_DMULH,
        K_RDMULH,
        K_NONE
    } lane_op_e;

    localparam int NUM_SIZES   = 3;   // lane widths 8, 16, 32
    localparam int BASE_ELEM_W = 8;

endpackage

// File: rtl/simd_lane_decode.sv
module simd_lane_decode
    import simd_lane_pkg::*;
(
    input  logic [4:0] op_code,
    input  logic       op_u,
    input  logic [1:0] elem_size,
    output lane_op_e   kind,
    output logic       sgn,
    output logic       illegal
);

    always_comb begin
        kind    = K_NONE;
        sgn     = ~op_u;
        illegal = 1'b0;
        unique case (op_code)
            5'h00: kind = K_HADD;
            5'h02: kind = K_RHADD;
            5'h04: kind = K_HSUB;
            5'h0C: kind = K_MAX;
            5'h0D: kind = K_MIN;
            5'h0E: kind = K_ABD;
            5'h0F: kind = K_ABA;
            5'h12: kind = op_u ? K_MLS : K_MLA;
            5'h13: begin
                kind = op_u ? K_PMUL : K_MUL;
                if (op_u && elem_size != 2'd0) illegal = 1'b1;
            end
            5'h16: begin
                kind = op_u ? K_RDMULH : K_DMULH;
                sgn  = 1'b1;
                if (elem_size == 2'd0) illegal = 1'b1;
            end
            default: illegal = 1'b1;
        endcase
        if (elem_size == 2'd3) illegal = 1'b1;
    end

endmodule

// File: rtl/simd_lane_elem.sv
module simd_lane_elem
    import simd_lane_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_op_e       kind,
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   acc,
    output logic [W-1:0]   res,
    output logic           sat
);

    localparam int XW = W + 1;
    localparam int PW = 2 * W;
    localparam int DW = 2 * W + 2;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [DW-1:0] RND_ADD = DW'(1) << (W - 1);

    logic [XW-1:0] ea, eb, sum_x, rsum_x, dif_x, absd_x;
    logic          a_gt_b;
    logic [W-1:0]  absd, mul_lo, clmul;
    logic signed [PW-1:0] sprod;
    logic [DW-1:0] dbl, dsum;
    logic [W-1:0]  dhigh;
    logic          both_neg;

    // Extend lanes by one bit according to signedness
    assign ea     = sgn ? {a[W-1], a} : {1'b0, a};
    assign eb     = sgn ? {b[W-1], b} : {1'b0, b};
    assign sum_x  = ea + eb;
    assign rsum_x = ea + eb + XW'(1);
    assign dif_x  = ea - eb;
    assign a_gt_b = $signed(ea) > $signed(eb);
    assign absd_x = dif_x[XW-1] ? (~dif_x + XW'(1)) : dif_x;
    assign absd   = W'(absd_x);
    assign mul_lo = W'(a * b);

    // Carry-less product, low W bits kept
    always_comb begin
        clmul = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) clmul = clmul ^ W'(a << i);
        end
    end

    // Doubling multiply high half
    assign sprod    = $signed(a) * $signed(b);
    assign dbl      = {sprod[PW-1], sprod, 1'b0};
    assign dsum     = dbl + ((kind == K_RDMULH) ? RND_ADD : '0);
    assign dhigh    = W'(dsum >> W);
    assign both_neg = (a == MOST_NEG) && (b == MOST_NEG);

    always_comb begin
        res = '0;
        sat = 1'b0;
        unique case (kind)
            K_HADD:  res = W'(sum_x >> 1);
            K_RHADD: res = W'(rsum_x >> 1);
            K_HSUB:  res = W'(dif_x >> 1);
            K_MAX:   res = a_gt_b ? a : b;
            K_MIN:   res = a_gt_b ? b : a;
            K_ABD:   res = absd;
            K_ABA:   res = absd + acc;
            K_MUL:   res = mul_lo;
            K_MLA:   res = acc + mul_lo;
            K_MLS:   res = acc - mul_lo;
            K_PMUL:  res = clmul;
            K_DMULH, K_RDMULH: begin
                res = both_neg ? MOST_POS : dhigh;
                sat = both_neg;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_lane_pkg::*;
#(
    parameter int CHUNK_W = 32,
    parameter int ELEM_W  = 8
) (
    input  lane_op_e             kind,
    input  logic                 sgn,
    input  logic [CHUNK_W-1:0]   a,
    input  logic [CHUNK_W-1:0]   b,
    input  logic [CHUNK_W-1:0]   acc,
    output logic [CHUNK_W-1:0]   res,
    output logic                 sat
);

    localparam int LANES = CHUNK_W / ELEM_W;

    logic [LANES-1:0] lane_sat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_lane_elem #(.W(ELEM_W)) u_elem (
            .kind (kind),
            .sgn  (sgn),
            .a    (a[g*ELEM_W +: ELEM_W]),
            .b    (b[g*ELEM_W +: ELEM_W]),
            .acc  (acc[g*ELEM_W +: ELEM_W]),
            .res  (res[g*ELEM_W +: ELEM_W]),
            .sat  (lane_sat[g])
        );
    end

    assign sat = |lane_sat;

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_lane_pkg::*;
#(
    parameter int CHUNK_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [4:0]         op_code,
    input  logic               op_u,
    input  logic [1:0]         elem_size,
    input  logic [CHUNK_W-1:0] src_a,
    input  logic [CHUNK_W-1:0] src_b,
    input  logic [CHUNK_W-1:0] acc_in,
    output logic               out_valid,
    output logic [CHUNK_W-1:0] out_data,
    output logic               out_sat,
    output logic               out_illegal
);

    typedef struct packed {
        logic               vld;
        logic [CHUNK_W-1:0] data;
        logic               sat;
        logic               ill;
    } out_state_t;

    lane_op_e           kind;
    logic               sgn;
    logic               illegal;
    logic [CHUNK_W-1:0] bank_res [NUM_SIZES];
    logic [NUM_SIZES-1:0] bank_sat;
    out_state_t         st_d, st_q;

    simd_lane_decode u_decode (
        .op_code   (op_code),
        .op_u      (op_u),
        .elem_size (elem_size),
        .kind      (kind),
        .sgn       (sgn),
        .illegal   (illegal)
    );

    // One lane bank per supported lane width
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
        simd_lane_bank #(
            .CHUNK_W (CHUNK_W),
            .ELEM_W  (BASE_ELEM_W << s)
        ) u_bank (
            .kind (kind),
            .sgn  (sgn),
            .a    (src_a),
            .b    (src_b),
            .acc  (acc_in),
            .res  (bank_res[s]),
            .sat  (bank_sat[s])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            st_d.ill = illegal;
            st_d.sat = 1'b0;
            st_d.data = '0;
            if (!illegal) begin
                unique case (elem_size)
                    2'd0: begin st_d.data = bank_res[0]; st_d.sat = bank_sat[0]; end
                    2'd1: begin st_d.data = bank_res[1]; st_d.sat = bank_sat[1]; end
                    2'd2: begin st_d.data = bank_res[2]; st_d.sat = bank_sat[2]; end
                    default: begin st_d.data = '0; st_d.sat = 1'b0; end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_data    = st_q.data;
    assign out_sat     = st_q.sat;
    assign out_illegal = st_q.ill;

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
    parameter int CHUNK_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [4:0]         op_code,
    input logic               op_u,
    input logic [1:0]         elem_size,
    input logic               out_valid,
    input logic [CHUNK_W-1:0] out_data,
    input logic               out_sat,
    input logic               out_illegal
);

    p_size3_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && elem_size == 2'd3 |=> out_illegal && out_data == '0 && !out_sat);

    p_illegal_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_illegal |-> out_data == '0 && !out_sat);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_data) && $stable(out_illegal) && $stable(out_sat));

    p_pmul_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code == 5'h13 && op_u && elem_size != 2'd0 |=> out_illegal);

    p_dmulh_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code == 5'h16 && elem_size == 2'd0 |=> out_illegal);

    p_sat_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_code != 5'h16 |=> !out_sat);

endmodule

bind simd_lane_alu simd_lane_alu_chk #(.CHUNK_W(CHUNK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_code     (op_code),
    .op_u        (op_u),
    .elem_size   (elem_size),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_sat     (out_sat),
    .out_illegal (out_illegal)
);

// File: tb/simd_lane_alu_tb.sv
`timescale 1ns/1ps
module simd_lane_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic        op_u = 1'b0;
    logic [1:0]  elem_size = '0;
    logic [31:0] src_a = '0, src_b = '0, acc_in = '0;
    logic        out_valid, out_sat, out_illegal;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    simd_lane_alu #(.CHUNK_W(32)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_code (op_code),
        .op_u (op_u), .elem_size (elem_size), .src_a (src_a), .src_b (src_b),
        .acc_in (acc_in), .out_valid (out_valid), .out_data (out_data),
        .out_sat (out_sat), .out_illegal (out_illegal)
    );

    function automatic longint sx(longint v, int w);
        if ((v >> (w - 1)) & 1) return v - (longint'(1) << w);
        return v;
    endfunction

    function automatic bit is_illegal(int op, bit u, int sz);
        bit known = (op == 0 || op == 2 || op == 4 || op == 12 || op == 13 ||
                     op == 14 || op == 15 || op == 18 || op == 19 || op == 22);
        if (sz == 3 || !known) return 1;
        if (op == 22 && sz == 0) return 1;
        if (op == 19 && u && sz != 0) return 1;
        return 0;
    endfunction

    function automatic string tag_of(int op, bit u, int sz);
        if (is_illegal(op, u, sz)) begin
            if (op == 19) return "R6";
            if (op == 22) return "R8";
            return "R1";
        end
        case (op)
            0, 2, 4:  return "R3";
            12, 13:   return "R4";
            14, 15:   return "R5";
            18:       return "R7";
            19:       return "R6";
            default:  return "R8";
        endcase
    endfunction

    task automatic model(input int op, input bit u, input int sz,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                         output logic [31:0] res, output bit sat, output bit ill);
        longint out, m, ra, rb, rc, sa, sb, r, mn;
        int w, n;
        ill = is_illegal(op, u, sz);
        res = '0; sat = 0;
        if (ill) return;
        w = 8 << sz; n = 32 / w;
        m = (longint'(1) << w) - 1;
        mn = -(longint'(1) << (w - 1));
        out = 0;
        for (int e = 0; e < n; e++) begin
            ra = (longint'(a) >> (e * w)) & m;
            rb = (longint'(b) >> (e * w)) & m;
            rc = (longint'(acc) >> (e * w)) & m;
            sa = (!u || op == 22) ? sx(ra, w) : ra;
            sb = (!u || op == 22) ? sx(rb, w) : rb;
            r = 0;
            case (op)
                0:  r = (sa + sb) >>> 1;
                2:  r = (sa + sb + 1) >>> 1;
                4:  r = (sa - sb) >>> 1;
                12: r = (sa > sb) ? sa : sb;
                13: r = (sa < sb) ? sa : sb;
                14: r = (sa > sb) ? sa - sb : sb - sa;
                15: r = ((sa > sb) ? sa - sb : sb - sa) + rc;
                18: r = u ? rc - ra * rb : rc + ra * rb;
                19: begin
                    if (u) begin
                        for (int i = 0; i < 8; i++) if ((rb >> i) & 1) r = r ^ (ra << i);
                    end else r = ra * rb;
                end
                default: begin
                    if (sa == mn && sb == mn) begin
                        r = -mn - 1; sat = 1;
                    end else begin
                        r = (2 * sa * sb + (u ? (longint'(1) << (w - 1)) : 0)) >>> w;
                    end
                end
            endcase
            out = out | ((r & m) << (e * w));
        end
        res = 32'(out);
    endtask

    task automatic check(input string tag, input logic [31:0] d, input logic s,
                         input logic i, input logic v,
                         input logic [31:0] ed, input logic es, input logic ei, input logic ev);
        n_checks++;
        if (d !== ed || s !== es || i !== ei || v !== ev) begin
            n_fail++;
            $display("FAIL %s: data=%h sat=%b ill=%b vld=%b expected data=%h sat=%b ill=%b vld=%b",
                     tag, d, s, i, v, ed, es, ei, ev);
        end
    endtask

    task automatic run_op(input int op, input bit u, input int sz,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
        logic [31:0] er; bit es, ei;
        model(op, u, sz, a, b, acc, er, es, ei);
        in_valid = 1; op_code = 5'(op); op_u = u; elem_size = 2'(sz);
        src_a = a; src_b = b; acc_in = acc;
        @(posedge clk); @(negedge clk);
        check(tag_of(op, u, sz), out_data, out_sat, out_illegal, out_valid, er, es, ei, 1'b1);
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    localparam int NOPS = 10;
    localparam int NCOR = 8;
    int ops [NOPS] = '{0, 2, 4, 12, 13, 14, 15, 18, 19, 22};
    logic [31:0] corners [NCOR] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_8000,
                                    32'h8080_8080, 32'h7F7F_7F7F, 32'h0101_0101, 32'h7FFF_FFFF};

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] hd; logic hs, hi;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", out_data, out_sat, out_illegal, out_valid, 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // Legal operations across sizes, variants, corners and random data
        for (int sz = 0; sz < 3; sz++) begin
            for (int k = 0; k < NOPS; k++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int i = 0; i < NCOR; i++)
                        for (int j = 0; j < NCOR; j++)
                            run_op(ops[k], u[0], sz, corners[i], corners[j], corners[(i + j) % NCOR]);
                    for (int r = 0; r < 24; r++)
                        run_op(ops[k], u[0], sz, next_rand(), next_rand(), next_rand());
                end
            end
        end

        // R9: saturation, most-negative lanes in a mix with ordinary lanes
        run_op(22, 1'b0, 1, 32'h8000_1234, 32'h8000_0003, 32'h0);
        run_op(22, 1'b1, 2, 32'h8000_0000, 32'h8000_0000, 32'h0);
        run_op(22, 1'b0, 1, 32'h8000_7FFF, 32'h7FFF_8000, 32'h0);

        // R1/R6/R8: encoding legality sweep
        for (int op = 0; op < 32; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int u = 0; u < 2; u++)
                    run_op(op, u[0], sz, next_rand(), next_rand(), next_rand());

        // R2: idle cycle keeps the previous result while inputs change
        run_op(18, 1'b1, 0, 32'h0102_0304, 32'h0506_0708, 32'hFFFF_FFFF);
        hd = out_data; hs = out_sat; hi = out_illegal;
        in_valid = 0; op_code = 5'h16; elem_size = 2'd3; src_a = 32'hDEAD_BEEF; src_b = 32'h8000_8000;
        @(posedge clk); @(negedge clk);
        check("R2", out_data, out_sat, out_illegal, out_valid, hd, hs, hi, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R2", out_data, out_sat, out_illegal, out_valid, hd, hs, hi, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule